// File: doc/BRIEF.md
# Floppy Command Spin-Up and Head-Load Sequencer

This block runs at the start of every floppy controller command that is not a pure interrupt request. When a command byte arrives, it works out what the mechanism needs before the command can run. In the motor-on variant it starts the spindle motor. In the head-load variant it loads or unloads the read/write head. It then adds up a start-up delay in milliseconds from several conditional parts.

The delay is converted to clock cycles. While the delay runs, the `waiting` output is held high. When the count expires, `proceed` pulses for one cycle. The command execution engine that follows uses this pulse to start.

Two inputs select the behaviour. `var_motor` picks the controller variant. `cmd_seek` marks a seek-class command (head positioning) as opposed to a data-transfer command. A command that arrives while a delay is still counting cancels it and starts its own delay.

Top module: `spinhl_seq`

## Requirements
- R1: After a synchronous reset, `motor_on`, `head_loaded`, `hlt_clear`, `waiting` and `proceed` are all 0.
- R2: A 30 ms settle part is added when command bit 2 is set and `cmd_seek` is 0. A seek-class command never gets this part.
- R3: In the motor-on variant (`var_motor`=1), a command sets `motor_on` to 1 in the cycle after it is accepted. `motor_on` then stays 1 until reset.
- R4: In the motor-on variant, a command that finds `motor_on` at 0 adds a 1200 ms spin-up part, unless command bit 3 is 1.
- R5: In the motor-on variant, a command that finds `motor_on` already 1 adds no spin-up part.
- R6: In the head-load variant (`var_motor`=0), a seek-class command with bit 3 set loads the head (`head_loaded`=1) and has a total delay of zero.
- R7: In the head-load variant, a seek-class command with bits 3 and 2 both 0 clears `head_loaded` and pulses `hlt_clear` for one cycle. A seek-class command with bit 3 at 0 and bit 2 at 1 leaves `head_loaded` unchanged and gives no pulse.
- R8: In the head-load variant, a non-seek command sets `head_loaded` and adds `hld_ms` milliseconds. A zero value of `hld_ms` adds nothing.
- R9: When the total delay is zero, `proceed` is 1 in the cycle right after acceptance, and `waiting` stays 0.
- R10: When the total delay is D ms, `waiting` is 1 for exactly D*CYCLES_PER_MS cycles after acceptance. `proceed` then follows for exactly one cycle.
- R11: A command accepted while `waiting` is 1 cancels the pending completion. Only the new command's delay produces a `proceed` pulse, timed from the new command.
- R12: A command in the motor-on variant does not change `head_loaded`. A command in the head-load variant does not change `motor_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_byte | input | 8 | Command byte; bit 2 enables settle, bit 3 is head-load (seek) or skip spin-up (motor variant) |
| cmd_seek | input | 1 | 1 = seek-class command |
| var_motor | input | 1 | 1 = motor-on variant, 0 = head-load variant |
| hld_ms | input | HLD_W | Programmable head-load time in ms |
| motor_on | output | 1 | Motor-on status and motor drive |
| head_loaded | output | 1 | Head-load drive |
| hlt_clear | output | 1 | One-cycle pulse that resets the head-load timing trigger |
| waiting | output | 1 | Start-up delay in progress |
| proceed | output | 1 | One-cycle pulse: command may execute |

## Verification
The delay sum is exercised with command patterns that each switch on a different set of parts:
- settle plus head-load time;
- spin-up alone;
- settle alone with the motor already running;
- settle with spin-up suppressed by bit 3;
- a zero head-load time.

Together these show whether each part is added only under its own condition. Seek-class patterns with bit 3 set, both bits clear, and only bit 2 set separate the load, unload and no-change head actions, and confirm that seek commands skip the settle time. A second command issued in the middle of a delay shows whether the old completion is truly dropped rather than also delivered.

// File: rtl/spinhl_pkg.sv
package spinhl_pkg;
  localparam int SETTLE_MS     = 30;
  localparam int SPINUP_MS     = 1200;
  localparam int BIT_DELAY_EN  = 2;
  localparam int BIT_HEAD_SKIP = 3;

  typedef struct packed {
    logic set_motor;
    logic load_head;
    logic drop_head;
  } action_t;
endpackage

// File: rtl/spinhl_plan.sv
module spinhl_plan
  import spinhl_pkg::*;
#(
  parameter int HLD_W = 8,
  parameter int MS_W  = 11
) (
  input  logic [7:0]       cmd_byte,
  input  logic             cmd_seek,
  input  logic             var_motor,
  input  logic             motor_now,
  input  logic [HLD_W-1:0] hld_ms,
  output action_t          act,
  output logic [MS_W-1:0]  total_ms
);
  logic [MS_W-1:0] settle_part;
  logic [MS_W-1:0] mech_part;

  always_comb begin
    settle_part = '0;
    if (cmd_byte[BIT_DELAY_EN] && !cmd_seek)
      settle_part = MS_W'(SETTLE_MS);
  end

  always_comb begin
    act       = '0;
    mech_part = '0;
    if (var_motor) begin
      if (!motor_now) begin
        act.set_motor = 1'b1;
        if (!cmd_byte[BIT_HEAD_SKIP])
          mech_part = MS_W'(SPINUP_MS);
      end
    end else if (cmd_seek) begin
      if (cmd_byte[BIT_HEAD_SKIP])
        act.load_head = 1'b1;
      else if (!cmd_byte[BIT_DELAY_EN])
        act.drop_head = 1'b1;
    end else begin
      act.load_head = 1'b1;
      mech_part     = MS_W'(hld_ms);
    end
  end

  assign total_ms = settle_part + mech_part;
endmodule

// File: rtl/spinhl_timer.sv
module spinhl_timer #(
  parameter int MS_W          = 11,
  parameter int CYCLES_PER_MS = 200_000,
  parameter int CNT_W         = 29
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [MS_W-1:0] delay_ms,
  output logic            waiting,
  output logic            proceed
);
  localparam bit POW2  = (CYCLES_PER_MS & (CYCLES_PER_MS - 1)) == 0;
  localparam int SHIFT = $clog2(CYCLES_PER_MS);

  logic [CNT_W-1:0] load_cycles;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (POW2) begin : g_shift
      assign load_cycles = CNT_W'(delay_ms) << SHIFT;
    end else begin : g_mult
      assign load_cycles = CNT_W'(delay_ms) * CNT_W'(CYCLES_PER_MS);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      waiting <= 1'b0;
      proceed <= 1'b0;
    end else begin
      proceed <= 1'b0;
      if (start) begin
        if (delay_ms == '0) begin
          waiting <= 1'b0;
          proceed <= 1'b1;
        end else begin
          cnt_q   <= load_cycles - CNT_W'(1);
          waiting <= 1'b1;
        end
      end else if (waiting) begin
        if (cnt_q == '0) begin
          waiting <= 1'b0;
          proceed <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spinhl_seq.sv
module spinhl_seq
  import spinhl_pkg::*;
#(
  parameter int CYCLES_PER_MS = 200_000,
  parameter int HLD_W         = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             cmd_seek,
  input  logic             var_motor,
  input  logic [HLD_W-1:0] hld_ms,
  output logic             motor_on,
  output logic             head_loaded,
  output logic             hlt_clear,
  output logic             waiting,
  output logic             proceed
);
  localparam int MAX_MS = SETTLE_MS + SPINUP_MS + (1 << HLD_W);
  localparam int MS_W   = $clog2(MAX_MS + 1);
  localparam int CNT_W  = $clog2(MAX_MS * CYCLES_PER_MS + 1);

  action_t         act;
  logic [MS_W-1:0] total_ms;

  spinhl_plan #(.HLD_W(HLD_W), .MS_W(MS_W)) u_plan (
    .cmd_byte (cmd_byte),
    .cmd_seek (cmd_seek),
    .var_motor(var_motor),
    .motor_now(motor_on),
    .hld_ms   (hld_ms),
    .act      (act),
    .total_ms (total_ms)
  );

  spinhl_timer #(.MS_W(MS_W), .CYCLES_PER_MS(CYCLES_PER_MS), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (cmd_valid),
    .delay_ms(total_ms),
    .waiting (waiting),
    .proceed (proceed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      motor_on    <= 1'b0;
      head_loaded <= 1'b0;
      hlt_clear   <= 1'b0;
    end else begin
      hlt_clear <= 1'b0;
      if (cmd_valid) begin
        if (act.set_motor) motor_on <= 1'b1;
        if (act.load_head) head_loaded <= 1'b1;
        if (act.drop_head) begin
          head_loaded <= 1'b0;
          hlt_clear   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spinhl_seq_chk.sv
module spinhl_seq_chk #(
  parameter int HLD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [7:0]       cmd_byte,
  input logic             cmd_seek,
  input logic             var_motor,
  input logic [HLD_W-1:0] hld_ms,
  input logic             motor_on,
  input logic             head_loaded,
  input logic             hlt_clear,
  input logic             waiting,
  input logic             proceed
);
  AST_PROCEED_CAUSED: assert property (@(posedge clk) disable iff (rst)
    proceed |-> ($past(waiting) || $past(cmd_valid))); // R10
  AST_WAIT_PROCEED_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(waiting && proceed)); // R10
  AST_WAIT_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(waiting) |-> $past(cmd_valid)); // R2
  AST_MOTOR_STICKY: assert property (@(posedge clk) disable iff (rst)
    motor_on |=> motor_on); // R3
  AST_HLT_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    hlt_clear |-> ($past(cmd_valid) && $past(cmd_seek) && !$past(var_motor) && !head_loaded)); // R7
  AST_MOTOR_KEEPS_HEAD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && var_motor) |=> $stable(head_loaded)); // R12
  AST_HEAD_KEEPS_MOTOR: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !var_motor) |=> $stable(motor_on)); // R12
endmodule

bind spinhl_seq spinhl_seq_chk #(.HLD_W(HLD_W)) u_chk (.*);

// File: tb/sim_spinhl_seq.sv
`timescale 1ns/1ps
module sim_spinhl_seq;
  localparam int CPM   = 4;
  localparam int HLD_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic cmd_seek = 1'b0;
  logic var_motor = 1'b0;
  logic [HLD_W-1:0] hld_ms = '0;
  logic motor_on, head_loaded, hlt_clear, waiting, proceed;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  int tag_q[$];
  int wait_cnt = 0;
  int hlt_pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spinhl_seq #(.CYCLES_PER_MS(CPM), .HLD_W(HLD_W)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .cmd_seek(cmd_seek), .var_motor(var_motor), .hld_ms(hld_ms),
    .motor_on(motor_on), .head_loaded(head_loaded), .hlt_clear(hlt_clear),
    .waiting(waiting), .proceed(proceed)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measure waiting length since last command, compare at proceed
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        wait_cnt = 0;
      end else begin
        if (hlt_clear) hlt_pulses++;
        if (cmd_valid) wait_cnt = waiting ? 1 : 0;
        else if (waiting) wait_cnt++;
        if (proceed) begin
          if (exp_q.size() == 0) begin
            check("R11 unexpected proceed", 1, 0);
          end else begin
            int e;
            int t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (wait_cnt != e) begin
              failures++;
              $display("FAIL R%0d/R10 wait cycles actual=%0d expected=%0d", t, wait_cnt, e);
            end
          end
          wait_cnt = 0;
        end
      end
    end
  end

  task automatic send(input logic [7:0] c, input logic s, input logic v, input int h);
    @(negedge clk);
    cmd_byte  = c;
    cmd_seek  = s;
    var_motor = v;
    hld_ms    = HLD_W'(h);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run(input logic [7:0] c, input logic s, input logic v, input int h,
                     input int exp_ms, input int tag);
    exp_q.push_back(exp_ms * CPM);
    tag_q.push_back(tag);
    send(c, s, v, h);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 motor_on", motor_on, 0);
    check("R1 head_loaded", head_loaded, 0);
    check("R1 hlt_clear", hlt_clear, 0);
    check("R1 waiting", waiting, 0);
    check("R1 proceed", proceed, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R6 R9: head variant seek with bit 3 -> load, zero delay
    run(8'h08, 1'b1, 1'b0, 50, 0, 6);
    check("R6 head_loaded", head_loaded, 1);
    check("R9 waiting stays low", waiting, 0);
    check("R12 motor untouched", motor_on, 0);
    drain();
    // R2 R8: settle + head-load time = 30 + 20
    run(8'h84, 1'b0, 1'b0, 20, 50, 8);
    check("R8 head_loaded", head_loaded, 1);
    drain();
    // R8 R9: zero head-load time, no settle
    run(8'h80, 1'b0, 1'b0, 0, 0, 8);
    drain();
    // R7 R2: seek with bit2 only -> head unchanged, no settle, no pulse
    run(8'h04, 1'b1, 1'b0, 20, 0, 7);
    check("R7 head kept", head_loaded, 1);
    drain();
    check("R7 no hlt pulse", hlt_pulses, 0);
    // R7: seek bits 3,2 clear -> unload + trigger pulse
    run(8'h00, 1'b1, 1'b0, 20, 0, 7);
    check("R7 head dropped", head_loaded, 0);
    drain();
    check("R7 one hlt pulse", hlt_pulses, 1);
    // R3 R4: motor variant, motor off, spin-up 1200 ms
    run(8'h80, 1'b0, 1'b1, 20, 1200, 4);
    check("R3 motor_on", motor_on, 1);
    check("R12 head untouched", head_loaded, 0);
    drain();
    // R5: motor already on -> settle only
    run(8'h84, 1'b0, 1'b1, 20, 30, 5);
    check("R3 motor stays on", motor_on, 1);
    drain();
    do_reset();
    // R4: bit 3 suppresses spin-up, settle 30
    run(8'h8C, 1'b0, 1'b1, 20, 30, 4);
    check("R3 motor_on after reset", motor_on, 1);
    drain();
    // R11: cancel a pending delay with a new command
    send(8'h84, 1'b0, 1'b0, 10);
    repeat (20) @(negedge clk);
    check("R11 first pending", waiting, 1);
    run(8'h80, 1'b0, 1'b0, 5, 5, 11);
    drain();
    repeat (200) @(negedge clk);
    check("R11 queue empty", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule